// File: doc/BRIEF.md
# Non-intrusive Frequent Loop Profiler

This block sits beside a processor's instruction-fetch address bus and listens to it without taking part. Each accepted fetch address is compared with the one accepted before it. A drop in address marks a taken backward branch, which is how loops close. Each such event is charged to the branch that caused it, keyed by the address of the branch instruction (the earlier, higher fetch). The block keeps counts for these branches in a small fully associative table. A sampling profiler would read the program counter at intervals; this block counts every loop closure instead.

The fetch stream is a valid-only stream: the block is always ready, has no ready output and applies no back-pressure, so the bus is never stalled and no traffic is altered. The entry with the highest count is presented on registered hot-loop outputs, giving the loop's branch address (upper bound) and target address (lower bound). Software can also inspect any table entry through a registered read port.

Top module: `loop_freq_profiler`

## Requirements
- R1: A backward-branch event is recorded when an accepted fetch (fetch_valid high) has an address strictly lower than the previous accepted fetch address; an equal or higher address is not an event, and the first accepted fetch after reset or clear is never an event.
- R2: An event whose branch address is not in the table takes the lowest-numbered empty entry, which becomes valid with branch address = previous fetch address, target = current fetch address and count 1.
- R3: An event whose branch address matches a valid entry adds one to that entry's count and creates no new entry.
- R4: An event that misses while every entry is valid replaces the entry with the lowest count (lowest index on a tie); the replaced entry gets the new addresses and count 1.
- R5: Counts are CNT_W bits wide and never reach 2^CNT_W-1: a hit on an entry whose count is 2^CNT_W-2 sets that entry to 2^(CNT_W-1)-1 and halves (rounding down) every other count in the same cycle.
- R6: The hot outputs show the valid entry with the highest count (lowest index on a tie); an event presented at clock edge k is in the table after edge k+1 and on the hot outputs after edge k+2; hot_valid is low while the table is empty.
- R7: A synchronous clear empties the table, clears the hot outputs at the same edge, drops an event in flight and forgets the previous fetch address.
- R8: The read port samples rd_idx at a clock edge and shows that entry's valid, branch address, target and count after that edge; an index of N or more reads all zeros.
- R9: While fetch_valid is low the address bus is ignored and the previous fetch address is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the table and history |
| fetch_valid | input | 1 | Fetch address on the bus is valid this cycle |
| fetch_addr | input | AW | Instruction-fetch address |
| rd_idx | input | $clog2(N) | Table entry to read |
| rd_valid | output | 1 | Read entry is valid |
| rd_branch | output | AW | Read entry branch address |
| rd_target | output | AW | Read entry target address |
| rd_count | output | CNT_W | Read entry count |
| hot_valid | output | 1 | A hottest loop exists |
| hot_branch | output | AW | Branch address of the hottest loop |
| hot_target | output | AW | Target address of the hottest loop |
| hot_count | output | CNT_W | Count of the hottest loop |

## Verification
A straight-line loop repeated several times separates counting of one branch from spurious inserts, while repeated and rising addresses show that non-decreasing fetches are not events and that gaps in fetch_valid keep the history. A ladder of branches with unequal counts fills the table and then misses, so replacement of the lowest count with its lowest-index tie rule is told apart from plain free-slot filling. A long run on one branch drives a count to its limit and shows the halving of all entries, and a clear raised one cycle after a branch shows that an event in flight is dropped. Counted latency from one branch to the hot outputs pins the two-edge lag.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  // Which extreme a selector searches for
  typedef enum logic {
    SEL_MIN = 1'b0,
    SEL_MAX = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/lfp_branch_detect.sv
module lfp_branch_detect #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic          ev_valid_o,
  output logic [AW-1:0] ev_src_o,
  output logic [AW-1:0] ev_tgt_o
);
  logic          last_v_q;
  logic [AW-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_v_q    <= 1'b0;
      last_addr_q <= '0;
      ev_valid_o  <= 1'b0;
      ev_src_o    <= '0;
      ev_tgt_o    <= '0;
    end else if (clr) begin
      last_v_q   <= 1'b0;
      ev_valid_o <= 1'b0;
    end else begin
      ev_valid_o <= fetch_valid_i && last_v_q && (fetch_addr_i < last_addr_q);
      if (fetch_valid_i) begin
        last_v_q    <= 1'b1;
        last_addr_q <= fetch_addr_i;
        ev_src_o    <= last_addr_q;
        ev_tgt_o    <= fetch_addr_i;
      end
    end
  end

  // R1: any event handed on points downward
  p_backward_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> (ev_tgt_o < ev_src_o));

  // R9: an idle bus cycle never yields an event
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid_i |=> !ev_valid_o);
endmodule

// File: rtl/lfp_select.sv
module lfp_select
  import lfp_pkg::*;
#(
  parameter int        N     = 12,
  parameter int        CNT_W = 16,
  parameter sel_mode_e MODE  = SEL_MAX
) (
  input  logic [N-1:0][CNT_W-1:0] cnt_i,
  input  logic [N-1:0]            valid_i,
  output logic                    found_o,
  output logic [$clog2(N)-1:0]    idx_o
);
  localparam int IW = $clog2(N);

  logic [CNT_W-1:0] best;
  logic             better;

  // Linear scan; strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    better  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (MODE == SEL_MAX) better = cnt_i[i] > best;
      else                 better = cnt_i[i] < best;
      if (valid_i[i] && (!found_o || better)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = cnt_i[i];
      end
    end
  end
endmodule

// File: rtl/lfp_table.sv
module lfp_table
  import lfp_pkg::*;
#(
  parameter int N     = 12,
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    ev_valid_i,
  input  logic [AW-1:0]           ev_src_i,
  input  logic [AW-1:0]           ev_tgt_i,
  input  logic [$clog2(N)-1:0]    rd_idx_i,
  output logic                    rd_valid_o,
  output logic [AW-1:0]           rd_branch_o,
  output logic [AW-1:0]           rd_target_o,
  output logic [CNT_W-1:0]        rd_count_o,
  output logic [N-1:0]            v_o,
  output logic [N-1:0][AW-1:0]    tag_o,
  output logic [N-1:0][AW-1:0]    tgt_o,
  output logic [N-1:0][CNT_W-1:0] cnt_o
);
  localparam int               IW   = $clog2(N);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF = CMAX >> 1;

  logic [N-1:0]            v_q;
  logic [N-1:0][AW-1:0]    tag_q;
  logic [N-1:0][AW-1:0]    tgt_q;
  logic [N-1:0][CNT_W-1:0] cnt_q;

  logic [N-1:0]  hit;
  logic          hit_any;
  logic [IW-1:0] hit_idx;
  logic          free_any;
  logic [IW-1:0] free_idx;
  logic          victim_found;
  logic [IW-1:0] victim_idx;
  logic [IW-1:0] ins_idx;
  logic          sat;

  // Per-entry tag compare
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = v_q[g] && (tag_q[g] == ev_src_i);
  end

  always_comb begin
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IW'(i);
      if (!v_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign hit_any = |hit;
  assign ins_idx = free_any ? free_idx : victim_idx;
  assign sat     = hit_any && (cnt_q[hit_idx] == CMAX - 1'b1);

  lfp_select #(.N(N), .CNT_W(CNT_W), .MODE(SEL_MIN)) u_victim (
    .cnt_i   (cnt_q),
    .valid_i (v_q),
    .found_o (victim_found),
    .idx_o   (victim_idx)
  );

  // Valid bits and counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      v_q   <= '0;
      cnt_q <= '0;
    end else if (ev_valid_i) begin
      if (hit_any) begin
        if (sat) begin
          for (int i = 0; i < N; i++)
            cnt_q[i] <= (IW'(i) == hit_idx) ? HALF : (cnt_q[i] >> 1);
        end else begin
          cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
        end
      end else begin
        v_q[ins_idx]   <= 1'b1;
        cnt_q[ins_idx] <= CNT_W'(1);
      end
    end
  end

  // Addresses need no reset: qualified by the valid bits
  always_ff @(posedge clk) begin
    if (ev_valid_i && !clr) begin
      if (hit_any) begin
        tgt_q[hit_idx] <= ev_tgt_i;
      end else begin
        tag_q[ins_idx] <= ev_src_i;
        tgt_q[ins_idx] <= ev_tgt_i;
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o  <= 1'b0;
      rd_branch_o <= '0;
      rd_target_o <= '0;
      rd_count_o  <= '0;
    end else if (int'(rd_idx_i) < N) begin
      rd_valid_o  <= v_q[rd_idx_i];
      rd_branch_o <= v_q[rd_idx_i] ? tag_q[rd_idx_i] : '0;
      rd_target_o <= v_q[rd_idx_i] ? tgt_q[rd_idx_i] : '0;
      rd_count_o  <= cnt_q[rd_idx_i];
    end else begin
      rd_valid_o  <= 1'b0;
      rd_branch_o <= '0;
      rd_target_o <= '0;
      rd_count_o  <= '0;
    end
  end

  assign v_o   = v_q;
  assign tag_o = tag_q;
  assign tgt_o = tgt_q;
  assign cnt_o = cnt_q;

  // R3: a branch address lives in at most one entry
  p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i |-> $onehot0(hit));

  // R2: a miss with room adds exactly one valid entry
  p_insert_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_i && !clr && !hit_any && free_any)
    |=> ($countones(v_q) == $past($countones(v_q)) + 1));

  // R4: a full table always offers a victim
  p_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_i && !hit_any && !free_any) |-> victim_found);

  // R7: clear leaves no valid entry
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (v_q == '0));

  // R8: out-of-range index reads as empty
  p_rd_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx_i) >= N) |=> (!rd_valid_o && rd_count_o == '0));

  // R5: no counter ever holds its all-ones value
  for (genvar g = 0; g < N; g++) begin : g_chk
    p_below_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] != CMAX);
  end
endmodule

// File: rtl/loop_freq_profiler.sv
module loop_freq_profiler
  import lfp_pkg::*;
#(
  parameter int N     = 12,
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 fetch_valid,
  input  logic [AW-1:0]        fetch_addr,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic                 rd_valid,
  output logic [AW-1:0]        rd_branch,
  output logic [AW-1:0]        rd_target,
  output logic [CNT_W-1:0]     rd_count,
  output logic                 hot_valid,
  output logic [AW-1:0]        hot_branch,
  output logic [AW-1:0]        hot_target,
  output logic [CNT_W-1:0]     hot_count
);
  localparam int IW = $clog2(N);

  logic                    ev_valid;
  logic [AW-1:0]           ev_src;
  logic [AW-1:0]           ev_tgt;
  logic [N-1:0]            tab_v;
  logic [N-1:0][AW-1:0]    tab_tag;
  logic [N-1:0][AW-1:0]    tab_tgt;
  logic [N-1:0][CNT_W-1:0] tab_cnt;
  logic                    max_found;
  logic [IW-1:0]           max_idx;

  lfp_branch_detect #(.AW(AW)) u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .fetch_valid_i (fetch_valid),
    .fetch_addr_i  (fetch_addr),
    .ev_valid_o    (ev_valid),
    .ev_src_o      (ev_src),
    .ev_tgt_o      (ev_tgt)
  );

  lfp_table #(.N(N), .AW(AW), .CNT_W(CNT_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .ev_valid_i  (ev_valid),
    .ev_src_i    (ev_src),
    .ev_tgt_i    (ev_tgt),
    .rd_idx_i    (rd_idx),
    .rd_valid_o  (rd_valid),
    .rd_branch_o (rd_branch),
    .rd_target_o (rd_target),
    .rd_count_o  (rd_count),
    .v_o         (tab_v),
    .tag_o       (tab_tag),
    .tgt_o       (tab_tgt),
    .cnt_o       (tab_cnt)
  );

  lfp_select #(.N(N), .CNT_W(CNT_W), .MODE(SEL_MAX)) u_hottest (
    .cnt_i   (tab_cnt),
    .valid_i (tab_v),
    .found_o (max_found),
    .idx_o   (max_idx)
  );

  // One register stage after the comparator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_valid  <= 1'b0;
      hot_branch <= '0;
      hot_target <= '0;
      hot_count  <= '0;
    end else if (clr || !max_found) begin
      hot_valid  <= 1'b0;
      hot_branch <= '0;
      hot_target <= '0;
      hot_count  <= '0;
    end else begin
      hot_valid  <= 1'b1;
      hot_branch <= tab_tag[max_idx];
      hot_target <= tab_tgt[max_idx];
      hot_count  <= tab_cnt[max_idx];
    end
  end

  // R6: a non-empty table is reported one edge later
  p_hot_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (max_found && !clr) |=> hot_valid);

  // R7: clear drops the hot report at once
  p_hot_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hot_valid);
endmodule

// File: tb/sim_loop_freq_profiler.sv
`timescale 1ns/1ps
module sim_loop_freq_profiler;
  localparam int N  = 6;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_valid;
  logic [AW-1:0] rd_branch;
  logic [AW-1:0] rd_target;
  logic [CW-1:0] rd_count;
  logic          hot_valid;
  logic [AW-1:0] hot_branch;
  logic [AW-1:0] hot_target;
  logic [CW-1:0] hot_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_freq_profiler #(.N(N), .AW(AW), .CNT_W(CW)) u0 (
    .clk, .rst_n, .clr, .fetch_valid, .fetch_addr, .rd_idx,
    .rd_valid, .rd_branch, .rd_target, .rd_count,
    .hot_valid, .hot_branch, .hot_target, .hot_count
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
  endtask

  task automatic settle();
    @(negedge clk);
    fetch_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    fetch_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic read_entry(input int idx, output logic v, output logic [AW-1:0] b,
                            output logic [AW-1:0] t, output logic [CW-1:0] c);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    v = rd_valid; b = rd_branch; t = rd_target; c = rd_count;
  endtask

  function automatic logic [AW-1:0] src_of(input int i);
    return AW'(16'h1080 + i * 16'h100);
  endfunction
  function automatic logic [AW-1:0] tgt_of(input int i);
    return AW'(16'h1000 + i * 16'h100);
  endfunction

  task automatic hit_branch(input int i, input int times);
    for (int k = 0; k < times; k++) begin
      fetch(src_of(i));
      fetch(tgt_of(i));
    end
  endtask

  task automatic t_reset();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    chk("R6 reset hot_valid", hot_valid, 0);
    read_entry(0, v, b, t, c);
    chk("R8 reset entry0 valid", v, 0);
    chk("R8 reset entry0 count", c, 0);
  endtask

  task automatic t_not_backward();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    do_clear();
    fetch(16'h0050); fetch(16'h0050); fetch(16'h0060);
    settle();
    read_entry(0, v, b, t, c);
    chk("R1 equal/rising addresses not events", v, 0);
    chk("R1 hot stays low", hot_valid, 0);
  endtask

  task automatic t_basic_loop();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    do_clear();
    for (int it = 0; it < 3; it++) begin
      fetch(16'h0100); fetch(16'h0104); fetch(16'h0108);
    end
    settle();
    read_entry(0, v, b, t, c);
    chk("R2 entry0 valid", v, 1);
    chk("R2 entry0 branch", b, 16'h0108);
    chk("R2 entry0 target", t, 16'h0100);
    chk("R3 entry0 count after two closures", c, 2);
    read_entry(1, v, b, t, c);
    chk("R3 no second entry", v, 0);
    chk("R6 hot branch", hot_branch, 16'h0108);
    chk("R6 hot target", hot_target, 16'h0100);
    chk("R6 hot count", hot_count, 2);
  endtask

  task automatic t_idle_gap();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    do_clear();
    fetch(16'h0300);
    @(negedge clk); fetch_valid = 1'b0; fetch_addr = 16'h0010;
    @(negedge clk); fetch_addr = 16'h0020;
    fetch(16'h0200);
    settle();
    read_entry(0, v, b, t, c);
    chk("R9 branch from last valid fetch", b, 16'h0300);
    chk("R9 target", t, 16'h0200);
    read_entry(1, v, b, t, c);
    chk("R9 idle addresses made no entry", v, 0);
  endtask

  task automatic t_hot_latency_tie();
    do_clear();
    fetch(16'h0100); fetch(16'h0080);
    @(negedge clk); fetch_valid = 1'b0;
    chk("R6 hot low after event edge", hot_valid, 0);
    @(negedge clk);
    chk("R6 hot low after table edge", hot_valid, 0);
    @(negedge clk);
    chk("R6 hot high two edges later", hot_valid, 1);
    chk("R6 hot count 1", hot_count, 1);
    do_clear();
    hit_branch(0, 2);
    hit_branch(1, 2);
    settle();
    chk("R6 tie picks lowest index", hot_branch, src_of(0));
    hit_branch(1, 1);
    settle();
    chk("R6 higher count wins", hot_branch, src_of(1));
    chk("R6 higher count value", hot_count, 3);
  endtask

  task automatic t_replace();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    int cnts[6] = '{3, 1, 2, 1, 2, 1};
    do_clear();
    for (int i = 0; i < 6; i++) hit_branch(i, cnts[i]);
    hit_branch(6, 1);
    settle();
    read_entry(1, v, b, t, c);
    chk("R4 victim is lowest count lowest index", b, src_of(6));
    chk("R4 new target", t, tgt_of(6));
    chk("R4 new count 1", c, 1);
    read_entry(3, v, b, t, c);
    chk("R4 other min entry kept", b, src_of(3));
    read_entry(0, v, b, t, c);
    chk("R4 top entry kept", c, 3);
    read_entry(7, v, b, t, c);
    chk("R8 out of range valid", v, 0);
    chk("R8 out of range branch", b, 0);
    chk("R8 out of range count", c, 0);
  endtask

  task automatic t_saturate();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    do_clear();
    hit_branch(0, 5);
    hit_branch(1, 254);
    settle();
    read_entry(1, v, b, t, c);
    chk("R5 count reaches 254", c, 254);
    hit_branch(1, 1);
    settle();
    read_entry(1, v, b, t, c);
    chk("R5 hit entry set to 127", c, 127);
    read_entry(0, v, b, t, c);
    chk("R5 other entry halved", c, 2);
    chk("R5 other entry still valid", v, 1);
    hit_branch(1, 1);
    settle();
    read_entry(1, v, b, t, c);
    chk("R5 counting resumes", c, 128);
    chk("R6 hot after halving", hot_branch, src_of(1));
  endtask

  task automatic t_clear();
    logic v; logic [AW-1:0] b, t; logic [CW-1:0] c;
    do_clear();
    chk("R7 hot cleared", hot_valid, 0);
    read_entry(1, v, b, t, c);
    chk("R7 table emptied", v, 0);
    fetch(16'h0100); fetch(16'h0080);
    do_clear();
    settle();
    read_entry(0, v, b, t, c);
    chk("R7 in-flight event dropped", v, 0);
    chk("R7 hot stays low", hot_valid, 0);
    fetch(16'h0040);
    settle();
    read_entry(0, v, b, t, c);
    chk("R7 history forgotten", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_not_backward();
    t_basic_loop();
    t_idle_gap();
    t_hot_latency_tie();
    t_replace();
    t_saturate();
    t_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule